// File: doc/BRIEF.md
# IO Translation Table Walker

This block turns a DMA virtual address into a physical address by walking a one-level translation table held in main memory. A request carries the low forty bits of the virtual address, a five-bit table selector and a flag that marks a DMA write. The walker looks up the selected 64-bit table descriptor in a local file of 32 registers and checks it. It then works out where the translation entry sits in memory and fetches that entry with a single read over a request/response handshake.

The memory returns the entry in little-endian byte order, so the walker reverses its bytes before decoding it. It checks the valid and write-permit bits, then reports either a physical address or a fault code that names the first check that failed. Only one walk is in flight at a time. Software loads the descriptor file through a simple write port.

Top module: `iotw_top`

## Requirements
- R1: `reqReady` is high only while the walker is idle. Once a request is accepted it stays low until the cycle after the result pulse, so only one walk is in flight.
- R2: A descriptor written at index i through `descWr*` is used by walks that select table i. Its layout is: valid at bit 63, table base address = bits 59:34 followed by 13 zero bits, page offset at bits 33:7, page-size code at bits 6:4, table-size code at bits 3:0. A clear valid bit gives fault code 1, and this check comes before every other check.
- R3: Page-size codes 2, 4, 6 and 7 give fault code 2, and no memory read is issued.
- R4: The page number is `reqVa[39:0]` shifted right by 13 + 3 × page-size code. If it is below the page offset, the result is fault code 3 with no memory read. Otherwise the adjusted page number is the page number minus the offset.
- R5: If the adjusted page number is greater than 1024 shifted left by the table-size code, the result is fault code 4 with no memory read. An adjusted page number equal to that count is accepted.
- R6: A walk that passes every descriptor check issues exactly one read at address base + 8 × adjusted page number. `memReqValid` and `memReqAddr` stay steady until `memReqReady` is seen.
- R7: The word returned on `memRspData` is byte-reversed before decoding. In the reversed word, bit 0 is valid, bit 1 is write-permit, bit 2 is key-valid, and bits 38:13 are the data address. A clear valid bit gives fault code 5.
- R8: A DMA write to an entry whose write-permit bit is clear gives fault code 6. A read of the same entry succeeds.
- R9: On success, `donePa` is the data address (bits 38:13 followed by 13 zero bits) ORed with the low 13 + 3 × page-size code bits of the virtual address. `doneKeyValid` copies the key-valid bit, and that bit never causes a fault.
- R10: Each walk ends with `doneValid` high for exactly one cycle. `doneFault` is 0 on success. On a fault, `donePa` and `doneKeyValid` are zero.
- R11: After reset, `reqReady` is high and `memReqValid` and `doneValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVa | input | 40 | Virtual address bits 39:0 |
| reqTable | input | 5 | Descriptor index |
| reqDmaWr | input | 1 | Request is a DMA write |
| descWrEn | input | 1 | Write strobe for the descriptor file |
| descWrIdx | input | 5 | Descriptor file index to write |
| descWrData | input | 64 | Descriptor value |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 39 | Entry address |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 64 | Entry word in little-endian byte order |
| doneValid | output | 1 | One-cycle result strobe |
| donePa | output | 40 | Translated physical address |
| doneFault | output | 3 | 0 on success, otherwise fault codes 1 to 6 |
| doneKeyValid | output | 1 | Key-valid bit of the entry |

## Verification
The bench targets the edges of the offset and range checks. It walks a page one below the offset and the page at exactly the last legal count, then the page one past that count. An off-by-one in either comparison shows up there as a wrong fault code or a spurious memory read. Every illegal page-size code is tried, along with a descriptor that is both invalid and of illegal size, so a wrong fault priority reports code 2 instead of 1. Walks at page-size codes 0, 1, 3 and 5 put known data addresses under wide virtual offsets. A wrong shift or mask then merges the wrong bits into the physical address. The memory model serves byte-swapped words at varying delays, so a missing byte reversal makes valid entries fault, and an address computed wrongly hits an empty location.

// File: rtl/iotw_pkg.sv
package iotw_pkg;

  localparam int VA_W      = 40;
  localparam int PA_W      = 40;
  localparam int MA_W      = 39;
  localparam int WORD_W    = 64;
  localparam int NUM_TBL   = 32;
  localparam int TBL_W     = $clog2(NUM_TBL);
  localparam int BASE_SH   = 13;
  localparam int FLT_W     = 3;
  localparam int SHAMT_W   = 6;
  localparam int PAGE_CNT0 = 1024;

  localparam logic [FLT_W-1:0] FLT_NONE   = 3'd0;
  localparam logic [FLT_W-1:0] FLT_DESC   = 3'd1;
  localparam logic [FLT_W-1:0] FLT_PGSZ   = 3'd2;
  localparam logic [FLT_W-1:0] FLT_UNDER  = 3'd3;
  localparam logic [FLT_W-1:0] FLT_RANGE  = 3'd4;
  localparam logic [FLT_W-1:0] FLT_ENTRY  = 3'd5;
  localparam logic [FLT_W-1:0] FLT_WRDENY = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_CALC, ST_MEMREQ, ST_MEMRESP, ST_DONE
  } walk_state_t;

  typedef struct packed {
    logic capReq;
    logic loadDesc;
    logic loadAddr;
    logic loadEntry;
  } walk_strobe_t;

endpackage

// File: rtl/iotw_ctrl.sv
module iotw_ctrl
  import iotw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                memReqReady,
  output logic                memReqValid,
  input  logic                memRspValid,
  input  logic [FLT_W-1:0]    calcFault,
  output logic                doneValid,
  output walk_strobe_t        stb
);

  walk_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_DESC;
      ST_DESC:    stateNext = ST_CALC;
      ST_CALC:    stateNext = (calcFault != FLT_NONE) ? ST_DONE : ST_MEMREQ;
      ST_MEMREQ:  if (memReqReady) stateNext = ST_MEMRESP;
      ST_MEMRESP: if (memRspValid) stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_MEMREQ);
  assign doneValid   = (state == ST_DONE);

  always_comb begin
    stb           = '0;
    stb.capReq    = (state == ST_IDLE) && reqValid;
    stb.loadDesc  = (state == ST_DESC);
    stb.loadAddr  = (state == ST_CALC);
    stb.loadEntry = (state == ST_MEMRESP) && memRspValid;
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

endmodule

// File: rtl/iotw_dpath.sv
module iotw_dpath
  import iotw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  walk_strobe_t        stb,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [TBL_W-1:0]    reqTable,
  input  logic                reqDmaWr,
  input  logic                descWrEn,
  input  logic [TBL_W-1:0]    descWrIdx,
  input  logic [WORD_W-1:0]   descWrData,
  input  logic [WORD_W-1:0]   memRspData,
  output logic [FLT_W-1:0]    calcFault,
  output logic [MA_W-1:0]     memReqAddr,
  output logic [PA_W-1:0]     donePa,
  output logic [FLT_W-1:0]    doneFault,
  output logic                doneKeyValid
);

  localparam int BYTES = WORD_W / 8;

  logic [WORD_W-1:0] descFile [NUM_TBL];
  logic [VA_W-1:0]   vaQ;
  logic [TBL_W-1:0]  tblQ;
  logic              wrQ;
  logic [WORD_W-1:0] descQ;
  logic [MA_W-1:0]   addrQ;
  logic [FLT_W-1:0]  faultQ;
  logic [PA_W-1:0]   paQ;
  logic              keyQ;

  always_ff @(posedge clk) begin
    if (descWrEn) descFile[descWrIdx] <= descWrData;
  end

  // descriptor fields
  logic              dValid;
  logic [25:0]       dBaseHi;
  logic [26:0]       dOffset;
  logic [2:0]        dPgSz;
  logic [3:0]        dTblSz;
  assign dValid  = descQ[63];
  assign dBaseHi = descQ[59:34];
  assign dOffset = descQ[33:7];
  assign dPgSz   = descQ[6:4];
  assign dTblSz  = descQ[3:0];

  logic [SHAMT_W-1:0] shiftAmt;
  logic [VA_W-1:0]    pageNum, adjPage, numPages, lowMask;
  logic               pgIllegal, under, outRange;
  logic [MA_W-1:0]    entryAddr;

  always_comb begin
    shiftAmt  = SHAMT_W'(BASE_SH) + SHAMT_W'(dPgSz) * SHAMT_W'(3);
    pageNum   = vaQ >> shiftAmt;
    lowMask   = (VA_W'(1) << shiftAmt) - VA_W'(1);
    pgIllegal = (dPgSz == 3'd2) || (dPgSz == 3'd4) || (dPgSz == 3'd6) || (dPgSz == 3'd7);
    under     = pageNum < VA_W'(dOffset);
    adjPage   = pageNum - VA_W'(dOffset);
    numPages  = VA_W'(PAGE_CNT0) << dTblSz;
    outRange  = adjPage > numPages;
    entryAddr = {dBaseHi, {BASE_SH{1'b0}}} + {adjPage[MA_W-4:0], 3'b000};
    if (!dValid)        calcFault = FLT_DESC;
    else if (pgIllegal) calcFault = FLT_PGSZ;
    else if (under)     calcFault = FLT_UNDER;
    else if (outRange)  calcFault = FLT_RANGE;
    else                calcFault = FLT_NONE;
  end

  // little-endian memory word to logical order
  logic [WORD_W-1:0] entry;
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign entry[8*b +: 8] = memRspData[8*(BYTES-1-b) +: 8];
  end

  logic              eValid, eWrite, eKey;
  logic [25:0]       eDataHi;
  logic [FLT_W-1:0]  entFault;
  assign eValid  = entry[0];
  assign eWrite  = entry[1];
  assign eKey    = entry[2];
  assign eDataHi = entry[38:13];

  always_comb begin
    if (!eValid)                entFault = FLT_ENTRY;
    else if (wrQ && !eWrite)    entFault = FLT_WRDENY;
    else                        entFault = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      tblQ   <= '0;
      wrQ    <= 1'b0;
      descQ  <= '0;
      addrQ  <= '0;
      faultQ <= FLT_NONE;
      paQ    <= '0;
      keyQ   <= 1'b0;
    end else begin
      if (stb.capReq) begin
        vaQ    <= reqVa;
        tblQ   <= reqTable;
        wrQ    <= reqDmaWr;
        faultQ <= FLT_NONE;
        paQ    <= '0;
        keyQ   <= 1'b0;
      end
      if (stb.loadDesc) descQ <= descFile[tblQ];
      if (stb.loadAddr) begin
        faultQ <= calcFault;
        addrQ  <= entryAddr;
      end
      if (stb.loadEntry) begin
        faultQ <= entFault;
        if (entFault == FLT_NONE) begin
          paQ  <= {1'b0, eDataHi, {BASE_SH{1'b0}}} | (vaQ & lowMask);
          keyQ <= eKey;
        end
      end
    end
  end

  assign memReqAddr   = addrQ;
  assign donePa       = paQ;
  assign doneFault    = faultQ;
  assign doneKeyValid = keyQ;

  logic unusedBits;
  assign unusedBits = ^{descQ[62:60], entry[63:39], entry[12:3]};

  assert_fault_code_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadAddr |=> doneFault <= FLT_RANGE);

endmodule

// File: rtl/iotw_top.sv
module iotw_top
  import iotw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic [39:0]  reqVa,
  input  logic [4:0]   reqTable,
  input  logic         reqDmaWr,
  input  logic         descWrEn,
  input  logic [4:0]   descWrIdx,
  input  logic [63:0]  descWrData,
  output logic         memReqValid,
  input  logic         memReqReady,
  output logic [38:0]  memReqAddr,
  input  logic         memRspValid,
  input  logic [63:0]  memRspData,
  output logic         doneValid,
  output logic [39:0]  donePa,
  output logic [2:0]   doneFault,
  output logic         doneKeyValid
);

  walk_strobe_t     stb;
  logic [FLT_W-1:0] calcFault;

  iotw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqReady (memReqReady),
    .memReqValid (memReqValid),
    .memRspValid (memRspValid),
    .calcFault   (calcFault),
    .doneValid   (doneValid),
    .stb         (stb)
  );

  iotw_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqVa        (reqVa),
    .reqTable     (reqTable),
    .reqDmaWr     (reqDmaWr),
    .descWrEn     (descWrEn),
    .descWrIdx    (descWrIdx),
    .descWrData   (descWrData),
    .memRspData   (memRspData),
    .calcFault    (calcFault),
    .memReqAddr   (memReqAddr),
    .donePa       (donePa),
    .doneFault    (doneFault),
    .doneKeyValid (doneKeyValid)
  );

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000);

  assert_fault_clears_pa_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault != 3'd0 |-> donePa == 40'd0 && !doneKeyValid);

endmodule

// File: tb/iotw_top_test.sv
`timescale 1ns/1ps
module iotw_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [39:0] reqVa = '0;
  logic [4:0]  reqTable = '0;
  logic        reqDmaWr = 1'b0;
  logic        descWrEn = 1'b0;
  logic [4:0]  descWrIdx = '0;
  logic [63:0] descWrData = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [38:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        doneValid;
  logic [39:0] donePa;
  logic [2:0]  doneFault;
  logic        doneKeyValid;

  always #2.5 clk = ~clk;

  iotw_top uut (.*);

  int checks = 0;
  int fails  = 0;
  int memCount = 0;
  logic [38:0] lastAddr = '0;
  bit finished = 1'b0;

  logic [63:0] tbDesc [32];
  logic [63:0] tbMem [logic [38:0]];

  typedef struct {
    logic [2:0]  flt;
    logic [39:0] pa;
    logic        key;
    int          memCnt;
    string       req;
  } exp_t;
  exp_t expQ[$];

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mkDesc(bit v, logic [38:0] base, logic [26:0] off,
                                         logic [2:0] pg, logic [3:0] sz);
    return {v, 3'b000, base[38:13], off, pg, sz};
  endfunction

  function automatic logic [63:0] mkEnt(logic [38:0] data, bit key, bit wr, bit v);
    return {16'hBEEF, 9'd0, data[38:13], 7'd0, 3'b101, key, wr, v};
  endfunction

  function automatic logic [63:0] bswap(logic [63:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = w[8*(7-i) +: 8];
    return r;
  endfunction

  // expected behaviour from the requirements
  task automatic refWalk(input logic [39:0] va, input logic [4:0] t, input bit wr,
                         output logic [2:0] flt, output logic [39:0] pa, output logic key,
                         output logic [38:0] addr, output bit usesMem);
    logic [63:0] d, e;
    int sh;
    logic [39:0] page, adj, cnt;
    d = tbDesc[t];
    flt = 0; pa = 0; key = 0; addr = 0; usesMem = 0;
    if (!d[63]) begin flt = 1; return; end
    if (d[6:4] inside {3'd2, 3'd4, 3'd6, 3'd7}) begin flt = 2; return; end
    sh = 13 + 3 * int'(d[6:4]);
    page = va >> sh;
    if (page < {13'd0, d[33:7]}) begin flt = 3; return; end
    adj = page - {13'd0, d[33:7]};
    cnt = 40'd1024 << d[3:0];
    if (adj > cnt) begin flt = 4; return; end
    addr = {d[59:34], 13'd0} + adj[38:0] * 8;
    usesMem = 1;
    e = tbMem.exists(addr) ? tbMem[addr] : 64'd0;
    if (!e[0]) begin flt = 5; return; end
    if (wr && !e[1]) begin flt = 6; return; end
    pa = {1'b0, e[38:13], 13'd0} | (va & ((40'd1 << sh) - 40'd1));
    key = e[2];
  endtask

  int expMem = 0;

  task automatic walk(logic [39:0] va, logic [4:0] t, bit wr, bit place,
                      logic [63:0] ent, string req);
    logic [2:0] f; logic [39:0] pa; logic k; logic [38:0] a; bit um;
    exp_t x;
    if (place) begin
      refWalk(va, t, wr, f, pa, k, a, um);
      tbMem[a] = ent;
    end
    refWalk(va, t, wr, f, pa, k, a, um);
    if (um) expMem++;
    x.flt = f; x.pa = pa; x.key = k; x.memCnt = expMem; x.req = req;
    expQ.push_back(x);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqVa = va; reqTable = t; reqDmaWr = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setDesc(int idx, logic [63:0] d);
    tbDesc[idx] = d;
    @(negedge clk);
    descWrEn = 1'b1; descWrIdx = idx[4:0]; descWrData = d;
    @(negedge clk);
    descWrEn = 1'b0;
  endtask

  // memory responder: byte-swapped data, varying delay
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (memReqValid && rstN) begin
        repeat (dly) @(negedge clk);
        dly = (dly + 1) % 3;
        memReqReady = 1'b1;
        lastAddr = memReqAddr;
        check(tbMem.exists(memReqAddr), "R6", "entry address present", {25'd0, memReqAddr}, 0);
        @(negedge clk);
        memReqReady = 1'b0;
        memCount++;
        repeat (dly) @(negedge clk);
        memRspValid = 1'b1;
        memRspData = tbMem.exists(lastAddr) ? bswap(tbMem[lastAddr]) : 64'd0;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (doneValid && rstN) begin
        exp_t x;
        if (expQ.size() == 0) begin
          check(0, "R10", "unexpected result", 1, 0);
        end else begin
          x = expQ.pop_front();
          check(doneFault == x.flt, x.req, "fault code", doneFault, x.flt);
          check(donePa == x.pa, x.req, "physical address", donePa, x.pa);
          check(doneKeyValid == x.key, "R9", "key valid", doneKeyValid, x.key);
          check(memCount == x.memCnt, "R6", "memory read count", memCount, x.memCnt);
          check(!reqReady, "R1", "ready low while busy", reqReady, 0);
          @(negedge clk);
          check(!doneValid, "R10", "single-cycle result", doneValid, 0);
          check(reqReady, "R1", "ready back after result", reqReady, 1);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1, "R11", "reset ready", reqReady, 1);
    check(memReqValid === 1'b0, "R11", "reset mem req", memReqValid, 0);
    check(doneValid === 1'b0, "R11", "reset done", doneValid, 0);

    setDesc(0,  mkDesc(1, 39'h12_3456_0000, 27'd4, 3'd0, 4'd0));
    setDesc(1,  mkDesc(0, 39'h12_3456_0000, 27'd0, 3'd0, 4'd0));
    setDesc(2,  mkDesc(1, 39'h00_2000_0000, 27'd0, 3'd2, 4'd0));
    setDesc(3,  mkDesc(1, 39'h00_2000_0000, 27'd0, 3'd4, 4'd0));
    setDesc(4,  mkDesc(1, 39'h00_2000_0000, 27'd0, 3'd6, 4'd0));
    setDesc(5,  mkDesc(1, 39'h00_2000_0000, 27'd0, 3'd7, 4'd0));
    setDesc(6,  mkDesc(1, 39'h00_8000_0000, 27'd0, 3'd1, 4'd2));
    setDesc(7,  mkDesc(1, 39'h01_0000_0000, 27'd2, 3'd3, 4'd5));
    setDesc(8,  mkDesc(0, 39'h00_2000_0000, 27'd0, 3'd2, 4'd0));
    setDesc(31, mkDesc(1, 39'h40_0000_0000, 27'd1, 3'd5, 4'd15));

    // R9 plain read, R6 address base + 8*adj
    walk(40'h00_0000_A123, 0, 0, 1, mkEnt(39'h00_ABCD_E000, 0, 1, 1), "R9");
    while (expQ.size() != 0) @(negedge clk);
    check(lastAddr == 39'h12_3456_0008, "R6", "entry address", {25'd0, lastAddr}, 64'h12_3456_0008);
    // R8 write permitted / denied / read of denied entry
    walk(40'h00_0000_A123, 0, 1, 0, 0, "R8");
    walk(40'h00_0000_C456, 0, 1, 1, mkEnt(39'h00_1111_2000, 0, 0, 1), "R8");
    walk(40'h00_0000_E001, 0, 0, 1, mkEnt(39'h00_2222_4000, 0, 0, 1), "R8");
    // R7 invalid entry
    walk(40'h00_0001_0000, 0, 0, 1, mkEnt(39'h00_3333_6000, 0, 1, 0), "R7");
    // R9 key-valid reported, no fault
    walk(40'h00_0001_2FFF, 0, 1, 1, mkEnt(39'h00_4444_8000, 1, 1, 1), "R9");
    // R2 invalid descriptor, and priority over bad page size
    walk(40'h00_0000_A123, 1, 0, 0, 0, "R2");
    walk(40'h00_0000_A123, 8, 0, 0, 0, "R2");
    // R3 illegal page sizes
    for (int t = 2; t <= 5; t++) walk(40'h00_0000_0000, t[4:0], 0, 0, 0, "R3");
    // R4 underflow
    walk(40'h00_0000_6000, 0, 0, 0, 0, "R4");
    walk(40'h00_0000_0000, 0, 0, 0, 0, "R4");
    // R5 equal count accepted, one past rejected
    walk(40'h00_0080_8000, 0, 0, 1, mkEnt(39'h00_5555_A000, 0, 1, 1), "R5");
    walk(40'h00_0080_A000, 0, 0, 0, 0, "R5");
    walk(40'h00_1001_0000, 6, 0, 0, 0, "R5");
    // R4/R9 other page sizes
    walk(40'h00_0012_3456, 6, 0, 1, mkEnt(39'h00_6600_0000, 0, 1, 1), "R4");
    walk(40'h00_03C1_2345, 7, 1, 1, mkEnt(39'h07_0000_0000, 0, 1, 1), "R9");
    walk(40'hAB_CDEF_1234, 31, 0, 1, mkEnt(39'h70_0000_0000, 1, 0, 1), "R9");
    // R2 descriptor rewrite takes effect
    setDesc(1, mkDesc(1, 39'h12_3456_0000, 27'd4, 3'd0, 4'd0));
    walk(40'h00_0000_A123, 1, 0, 0, 0, "R2");

    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule